// File: doc/BRIEF.md
# EDO DRAM output-drive controller

This block decides, cycle by cycle, whether each byte lane of a 16-bit extended-data-out DRAM data bus drives read data or floats. It sits on the device side of a synthesizable bus-functional responder. The responder's small storage array supplies the word at the currently addressed location on `rd_data_i`. The block watches the active-low row strobe, the two column strobes (one per byte lane), the write strobe and the output-enable strobe. It passes them through a clocked synchronizer, and each lane then runs its own state machine. That machine keeps a latched copy of the lane's read byte and produces a drive enable and a one-cycle write pulse toward the array. Analog turn-off delays are modelled as counts of clock cycles set by parameters.

Each lane state machine has six states. IDLE: no access, not driving. READ: column strobe low in a read, driving while output-enable is low. EDO_HOLD: column strobe back high with the row strobe still low, data held on the bus. OFF_WAIT: both strobes high, counting down the turn-off delay. PARKED: outputs disabled until the next column-strobe fall. WRITE: a write is in progress and the outputs are off.

The transitions are as follows. A column fall takes any state to IDLE (row strobe high: refresh), to READ (write strobe high, byte latched) or to WRITE (write strobe low, write pulse). READ goes to EDO_HOLD or OFF_WAIT on a column rise, depending on the row strobe. READ goes to WRITE on a write-strobe fall with output-enable high. EDO_HOLD goes to OFF_WAIT when the row strobe is high. EDO_HOLD goes to PARKED on a low write strobe or on a long enough output-enable high time. OFF_WAIT goes to IDLE when its count expires. WRITE goes to PARKED or IDLE on a column rise.

Top module: `edo_oe_top`

## Requirements
- R1: Reset forces both drive enables and both write pulses low and the latched data to zero, whatever the strobe pins do while reset is held.
- R2: A column-strobe fall with the row strobe low and write strobe high latches that lane's byte of `rd_data_i`. The lane then drives while output-enable is low and floats while it is high.
- R3: When the lane's column strobe rises with the row strobe low, write strobe high and output-enable low, the lane keeps driving the same latched byte.
- R4: If output-enable is high when the column strobe rises and then stays high for OE_HOLD_CYC synchronized cycles, the lane stops driving. It stays off, whatever output-enable does, until its column strobe falls again. A shorter high time lets the drive return when output-enable goes low.
- R5: If output-enable is low at the column rise and then goes high for OE_PULSE_CYC synchronized cycles before the next column fall, the lane stops driving until that fall. A shorter pulse does not disable it.
- R6: A low write strobe while the lane holds extended data disables the drive. The drive stays off after the write strobe returns high, until the column strobe falls with the write strobe high.
- R7: Once both the row strobe and the lane's column strobe are high, the lane keeps driving for OFF_DLY_CYC cycles, counted from the later of the two rises, and then stops.
- R8: A write-strobe fall during a read with output-enable low gives no write pulse, and the lane keeps driving its latched byte. With output-enable high, the same fall gives one write pulse and turns the drive off.
- R9: A column fall with the write strobe already low gives one single-cycle write pulse for that lane and no drive, whatever output-enable does.
- R10: Lane 0 (bits 7:0) follows only `cas_lo_n_i`, and lane 1 (bits 15:8) follows only `cas_hi_n_i`.
- R11: Latched data changes only on a column fall. A row-strobe fall while the column strobe is already low keeps the old byte and the drive.
- R12: A column fall with the row strobe high (refresh) leaves the lane not driving, with no write pulse and no change to the latched byte.
- R13: With two synchronizer stages, an output-enable pin change reaches the drive enables after the second following rising edge. A change on the row, column or write strobe pins reaches them after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_lo_n_i | input | 1 | Column strobe for bits 7:0, active low |
| cas_hi_n_i | input | 1 | Column strobe for bits 15:8, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_data_i | input | DQ_W | Word at the addressed location in the array |
| dq_o | output | DQ_W | Latched read data per lane |
| drive_en_o | output | 2 | Per-lane drive enable (bit 0 = low byte) |
| wr_en_o | output | 2 | Per-lane one-cycle write pulse to the array |

## Verification
The bench targets the two output-enable disable methods by applying pulses just below and well above each threshold. A design that counted from the wrong edge, or mixed up the two thresholds, would park the lane on the short pulse or keep it driving after the long one. It checks that a parked lane stays off after output-enable or the write strobe returns, and that an inhibited late write neither pulses nor drops the drive. A design with non-sticky disable flags or an unconditional late write would fail there. It also drives the row strobe low under an already-low column strobe and changes the array word. A design that reloaded on that edge, or cut the drive at the row rise instead of after the delay, would show the wrong byte or an early float.

// File: rtl/edo_oe_pkg.sv
package edo_oe_pkg;

    // Per-lane output-drive state
    typedef enum logic [2:0] {
        LS_IDLE     = 3'd0,
        LS_READ     = 3'd1,
        LS_EDO_HOLD = 3'd2,
        LS_OFF_WAIT = 3'd3,
        LS_PARKED   = 3'd4,
        LS_WRITE    = 3'd5
    } lane_state_t;

    // Bit positions inside the synchronized strobe bundle
    localparam int STB_W   = 5;
    localparam int STB_RAS = 4;
    localparam int STB_CLO = 3;
    localparam int STB_CHI = 2;
    localparam int STB_WE  = 1;
    localparam int STB_OE  = 0;

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
    import edo_oe_pkg::*;
#(
    parameter int LANE_W       = 8,
    parameter int OE_HOLD_CYC  = 4,
    parameter int OE_PULSE_CYC = 3,
    parameter int OFF_DLY_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_s,
    input  logic              cas_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic [LANE_W-1:0] rd_byte_i,
    output logic [LANE_W-1:0] data_o,
    output logic              drive_o,
    output logic              wr_o
);

    localparam int MAX_A   = (OE_HOLD_CYC > OE_PULSE_CYC) ? OE_HOLD_CYC : OE_PULSE_CYC;
    localparam int CNT_MAX = (MAX_A > OFF_DLY_CYC) ? MAX_A : OFF_DLY_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    lane_state_t       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W:0]    cnt_inc;
    logic [CNT_W:0]    oe_thr;
    logic              oe_at_rise_q, oe_at_rise_d;
    logic [LANE_W-1:0] data_q, data_d;
    logic              wr_q, wr_d;
    logic              cas_d1_q, we_d1_q;
    logic              cas_fall, cas_rise, we_fall;

    always_comb begin
        cas_fall = cas_d1_q & ~cas_s;
        cas_rise = ~cas_d1_q & cas_s;
        we_fall  = we_d1_q & ~we_s;
        cnt_inc  = {1'b0, cnt_q} + 1'b1;
        oe_thr   = oe_at_rise_q ? (CNT_W+1)'(OE_HOLD_CYC) : (CNT_W+1)'(OE_PULSE_CYC);
    end

    // Next-state logic
    always_comb begin
        st_d         = st_q;
        cnt_d        = cnt_q;
        oe_at_rise_d = oe_at_rise_q;
        data_d       = data_q;
        wr_d         = 1'b0;
        if (cas_fall) begin
            cnt_d = '0;
            if (ras_s) begin
                st_d = LS_IDLE;
            end else if (we_s) begin
                st_d   = LS_READ;
                data_d = rd_byte_i;
            end else begin
                st_d = LS_WRITE;
                wr_d = 1'b1;
            end
        end else begin
            unique case (st_q)
                LS_IDLE, LS_PARKED: begin
                end
                LS_READ: begin
                    if (cas_rise) begin
                        cnt_d        = '0;
                        oe_at_rise_d = oe_s;
                        st_d         = ras_s ? LS_OFF_WAIT : LS_EDO_HOLD;
                    end else if (we_fall && oe_s) begin
                        st_d = LS_WRITE;
                        wr_d = 1'b1;
                    end
                end
                LS_EDO_HOLD: begin
                    if (ras_s) begin
                        st_d  = LS_OFF_WAIT;
                        cnt_d = '0;
                    end else if (!we_s) begin
                        st_d = LS_PARKED;
                    end else if (oe_s) begin
                        if (cnt_inc >= oe_thr) st_d = LS_PARKED;
                        else cnt_d = cnt_inc[CNT_W-1:0];
                    end else begin
                        cnt_d = '0;
                    end
                end
                LS_OFF_WAIT: begin
                    if (cnt_inc >= (CNT_W+1)'(OFF_DLY_CYC)) st_d = LS_IDLE;
                    else cnt_d = cnt_inc[CNT_W-1:0];
                end
                LS_WRITE: begin
                    if (cas_rise) st_d = ras_s ? LS_IDLE : LS_PARKED;
                end
                default: st_d = LS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= LS_IDLE;
            cnt_q        <= '0;
            oe_at_rise_q <= 1'b0;
            data_q       <= '0;
            wr_q         <= 1'b0;
            cas_d1_q     <= 1'b1;
            we_d1_q      <= 1'b1;
        end else begin
            st_q         <= st_d;
            cnt_q        <= cnt_d;
            oe_at_rise_q <= oe_at_rise_d;
            data_q       <= data_d;
            wr_q         <= wr_d;
            cas_d1_q     <= cas_s;
            we_d1_q      <= we_s;
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            LS_READ, LS_EDO_HOLD, LS_OFF_WAIT: drive_o = ~oe_s;
            default:                           drive_o = 1'b0;
        endcase
        data_o = data_q;
        wr_o   = wr_q;
    end

    // R6 and R4/R5: a parked lane stays parked and silent until a column fall
    a_r6_parked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_PARKED && !cas_fall) |=> (st_q == LS_PARKED && !drive_o));

    a_r11_data_only_on_cas_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_fall |=> $stable(data_o));

    a_r8_late_write_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_READ && !cas_fall && !cas_rise && we_fall && !oe_s)
            |=> (st_q == LS_READ && !wr_o));

    a_r9_write_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    a_r7_off_wait_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_OFF_WAIT && !cas_fall && cnt_q == CNT_W'(OFF_DLY_CYC - 1))
            |=> (st_q == LS_IDLE));

    a_r12_refresh_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && ras_s) |=> (!drive_o && !wr_o));

endmodule

// File: rtl/edo_oe_top.sv
module edo_oe_top
    import edo_oe_pkg::*;
#(
    parameter int DQ_W         = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int OE_HOLD_CYC  = 4,
    parameter int OE_PULSE_CYC = 3,
    parameter int OFF_DLY_CYC  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ras_n_i,
    input  logic            cas_lo_n_i,
    input  logic            cas_hi_n_i,
    input  logic            we_n_i,
    input  logic            oe_n_i,
    input  logic [DQ_W-1:0] rd_data_i,
    output logic [DQ_W-1:0] dq_o,
    output logic [1:0]      drive_en_o,
    output logic [1:0]      wr_en_o
);

    localparam int LANES  = 2;
    localparam int LANE_W = DQ_W / LANES;

    logic [STB_W-1:0] stb_raw, stb_s;
    logic [LANES-1:0] cas_s;

    assign stb_raw = {ras_n_i, cas_lo_n_i, cas_hi_n_i, we_n_i, oe_n_i};

    edo_strobe_sync #(
        .W       (STB_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({STB_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stb_raw),
        .sync_o  (stb_s)
    );

    assign cas_s = {stb_s[STB_CHI], stb_s[STB_CLO]};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctrl #(
            .LANE_W       (LANE_W),
            .OE_HOLD_CYC  (OE_HOLD_CYC),
            .OE_PULSE_CYC (OE_PULSE_CYC),
            .OFF_DLY_CYC  (OFF_DLY_CYC)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ras_s     (stb_s[STB_RAS]),
            .cas_s     (cas_s[g]),
            .we_s      (stb_s[STB_WE]),
            .oe_s      (stb_s[STB_OE]),
            .rd_byte_i (rd_data_i[g*LANE_W +: LANE_W]),
            .data_o    (dq_o[g*LANE_W +: LANE_W]),
            .drive_o   (drive_en_o[g]),
            .wr_o      (wr_en_o[g])
        );
    end

    // R10: a lane whose own column strobe has stayed high cannot start a write
    a_r10_lane_own_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_s[0] && $past(cas_s[0])) |=> !wr_en_o[0]);

endmodule

// File: tb/edo_oe_top_tb.sv
module edo_oe_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n, cas_lo_n, cas_hi_n, we_n, oe_n;
    logic [15:0] rd_data;
    logic [15:0] dq;
    logic [1:0]  drive_en, wr_en;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_lo_cnt = 0;
    int wr_hi_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edo_oe_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n_i    (ras_n),
        .cas_lo_n_i (cas_lo_n),
        .cas_hi_n_i (cas_hi_n),
        .we_n_i     (we_n),
        .oe_n_i     (oe_n),
        .rd_data_i  (rd_data),
        .dq_o       (dq),
        .drive_en_o (drive_en),
        .wr_en_o    (wr_en)
    );

    always @(negedge clk) begin
        if (wr_en[0]) wr_lo_cnt++;
        if (wr_en[1]) wr_hi_cnt++;
    end

    // Pins {ras,cas_lo,cas_hi,we,oe} | wait | expected {lane0,lane1} | req
    localparam int NV = 37;
    localparam logic [14:0] TBL [NV] = '{
        15'b11111_0011_00_0001,  // R1 idle
        15'b01111_0011_00_0010,  // R2 row only
        15'b00011_0011_00_0010,  // R2 read, OE high floats
        15'b00010_0011_11_0010,  // R2 OE low drives
        15'b01110_0011_11_0011,  // R3 extended hold
        15'b01110_0100_11_0011,  // R3 still held
        15'b01111_0001_11_1101,  // R13 OE change not yet seen
        15'b01110_0100_11_0101,  // R5 short pulse, drive returns
        15'b01111_0110_00_0101,  // R5 long pulse parks
        15'b01110_0011_00_0101,  // R5 stays parked
        15'b00010_0011_11_0010,  // R2 new read
        15'b00011_0011_00_0010,  // R2 OE high floats
        15'b01111_0010_00_0100,  // R4 rise with OE high, short
        15'b01110_0011_11_0100,  // R4 drive returns
        15'b00011_0011_00_0010,  // R2 read with OE high
        15'b01111_1000_00_0100,  // R4 long hold parks
        15'b01110_0011_00_0100,  // R4 parked despite OE low
        15'b00010_0011_11_0010,  // R2 read
        15'b01110_0011_11_0011,  // R3 hold
        15'b01100_0011_00_0110,  // R6 write strobe disables
        15'b01110_0100_00_0110,  // R6 stays off
        15'b00010_0011_11_0110,  // R6 column fall with WE high
        15'b00000_0011_11_1000,  // R8 inhibited late write
        15'b01100_0100_00_0110,  // R6 rise with WE low parks
        15'b01110_0011_00_0110,  // R6 parked
        15'b00010_0011_11_0010,  // R2 read
        15'b01110_0011_11_0011,  // R3 hold
        15'b11110_0100_11_0111,  // R7 still inside delay
        15'b11110_0010_00_0111,  // R7 delay expired
        15'b01110_0011_00_0010,  // R2 row only
        15'b00110_0011_10_1010,  // R10 lower lane only
        15'b00010_0011_11_1010,  // R10 both lanes
        15'b01010_0011_11_1010,  // R10 lower holds, upper reads
        15'b11110_1000_00_0111,  // R7 all off
        15'b10010_0011_00_1100,  // R12 refresh, no drive
        15'b00010_0011_00_1100,  // R12 row fall after refresh
        15'b11110_0011_00_1100   // R12 back to idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pins(input logic [4:0] p);
        {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n} = p;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int w0;
        int w1;
        rst_n   = 1'b0;
        rd_data = 16'h0000;
        pins(5'b11111);
        hold(3);
        chk("R1 drive", {30'd0, drive_en}, 32'd0);
        chk("R1 wr", {30'd0, wr_en}, 32'd0);
        chk("R1 dq", {16'd0, dq}, 32'd0);
        rst_n = 1'b1;
        hold(2);

        rd_data = 16'hA55A;
        for (int i = 0; i < NV; i++) begin
            pins(TBL[i][14:10]);
            hold(int'(TBL[i][9:6]));
            chk($sformatf("R%0d step %0d", TBL[i][3:0], i),
                {30'd0, drive_en[0], drive_en[1]}, {30'd0, TBL[i][5:4]});
        end

        // R2 / R3 data path
        rd_data = 16'h12AB;
        pins(5'b01110); hold(3);
        pins(5'b00010); hold(3);
        chk("R2 dq", {16'd0, dq}, 32'h12AB);
        rd_data = 16'h5566;
        pins(5'b01110); hold(3);
        chk("R3 dq held", {16'd0, dq}, 32'h12AB);
        chk("R3 drive", {30'd0, drive_en}, 32'd3);
        pins(5'b00010); hold(3);
        chk("R2 reload", {16'd0, dq}, 32'h5566);

        // R8 late write with OE low: ignored
        w0 = wr_lo_cnt; w1 = wr_hi_cnt;
        pins(5'b00000); hold(4);
        chk("R8 no pulse lo", wr_lo_cnt - w0, 0);
        chk("R8 no pulse hi", wr_hi_cnt - w1, 0);
        chk("R8 still drives", {30'd0, drive_en}, 32'd3);
        chk("R8 data kept", {16'd0, dq}, 32'h5566);
        pins(5'b01100); hold(4);

        // R8 late write with OE high: one pulse per lane
        pins(5'b00010); hold(3);
        pins(5'b00011); hold(3);
        w0 = wr_lo_cnt; w1 = wr_hi_cnt;
        pins(5'b00001); hold(4);
        chk("R8 pulse lo", wr_lo_cnt - w0, 1);
        chk("R8 pulse hi", wr_hi_cnt - w1, 1);
        chk("R8 drive off", {30'd0, drive_en}, 32'd0);
        pins(5'b01101); hold(3);

        // R9 early write with OE low
        w0 = wr_lo_cnt; w1 = wr_hi_cnt;
        pins(5'b00000); hold(5);
        chk("R9 pulse lo", wr_lo_cnt - w0, 1);
        chk("R9 pulse hi", wr_hi_cnt - w1, 1);
        chk("R9 no drive", {30'd0, drive_en}, 32'd0);
        pins(5'b11111); hold(8);

        // R11 row fall under a low column strobe
        rd_data = 16'hA1A1;
        pins(5'b01110); hold(3);
        pins(5'b00010); hold(3);
        pins(5'b10010); hold(3);
        chk("R11 drive with row high", {30'd0, drive_en}, 32'd3);
        rd_data = 16'hB2B2;
        pins(5'b00010); hold(3);
        chk("R11 data kept", {16'd0, dq}, 32'hA1A1);
        chk("R11 drive kept", {30'd0, drive_en}, 32'd3);
        pins(5'b01110); hold(3);
        pins(5'b00010); hold(3);
        chk("R11 reload on fall", {16'd0, dq}, 32'hB2B2);
        pins(5'b11110); hold(8);

        // R12 refresh leaves data and writes alone
        w0 = wr_lo_cnt;
        rd_data = 16'h7777;
        pins(5'b10010); hold(4);
        chk("R12 data", {16'd0, dq}, 32'hB2B2);
        chk("R12 no write", wr_lo_cnt - w0, 0);
        pins(5'b11110); hold(3);

        // R10 byte-lane split
        rd_data = 16'hC33C;
        pins(5'b01110); hold(3);
        pins(5'b00110); hold(3);
        chk("R10 low byte", {24'd0, dq[7:0]}, 32'h3C);
        chk("R10 high byte kept", {24'd0, dq[15:8]}, 32'hB2);
        chk("R10 enables", {30'd0, drive_en}, 32'd1);
        pins(5'b11110); hold(8);

        // R13 latency of OE
        pins(5'b01110); hold(3);
        pins(5'b00010); hold(3);
        pins(5'b00011); hold(1);
        chk("R13 before sync", {30'd0, drive_en}, 32'd3);
        hold(1);
        chk("R13 after sync", {30'd0, drive_en}, 32'd0);
        pins(5'b00010); hold(3);

        // R1 reset in the middle of a driving read
        rst_n = 1'b0;
        hold(2);
        chk("R1 mid reset drive", {30'd0, drive_en}, 32'd0);
        chk("R1 mid reset dq", {16'd0, dq}, 32'd0);
        pins(5'b11111);
        hold(2);
        rst_n = 1'b1;
        hold(4);
        chk("R1 after release", {30'd0, drive_en}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule